// File: doc/BRIEF.md
# Paged Program-Memory Table Read Unit

This unit lets a small microcontroller core pull constant data out of its 14-bit-wide program memory. It keeps an 8-bit table pointer and a read-only high-byte register, both reachable on the core's register-file bus. The core issues one of two table-read commands. The current-page form takes the page number from the upper program counter bits. The last-page form always reads from the top page of program memory.

Each command splits the fetched 14-bit word into two parts. The low byte is written to the data-memory address given with the command. The remaining six bits are zero-extended into the high-byte register. A command takes two cycles. In the issue cycle the unit drives a synchronous ROM read and raises a stall. In the following cycle the ROM word comes back, the data-memory write strobe fires, and the high-byte register loads at the end of that cycle.

Top module: `tblrd_top`

## Requirements
- R1: After reset the table pointer reads 00h, the high-byte register reads 00h, and no data-memory write or ROM read is driven.
- R2: A register-bus write to address 07h loads the table pointer, and a read of 07h returns it from the next cycle on.
- R3: A register-bus write to address 08h has no effect: the high-byte register keeps its value.
- R4: A current-page command (`cmdLastPage`=0) drives `romEn`=1 in its issue cycle, with `romAddr` = {`pcHi`, table pointer}, where `pcHi` is program counter bits 9..8 in romAddr bits 9..8.
- R5: A last-page command (`cmdLastPage`=1) drives `romAddr` = {2'b11, table pointer} in its issue cycle.
- R6: `busy` is 1 in the issue cycle of a command and 0 in every other cycle.
- R7: In the cycle after issue, `dmWrEn`=1, `dmWrAddr` equals the destination sampled at issue, and `dmWrData` equals word bits 7..0.
- R8: From the cycle after the write cycle, a read of address 08h returns {2'b00, word bits 13..8}.
- R9: A command presented during the write cycle is ignored: there is no ROM read, no stall and no second write.
- R10: A register-bus read of any address other than 07h and 08h returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Table-read command request |
| cmdLastPage | input | 1 | 1 selects the last page, 0 the current page |
| cmdDest | input | 8 | Destination data-memory address for the low byte |
| pcHi | input | 2 | Program counter bits 9..8 |
| regAddr | input | 8 | Register-bus address |
| regWr | input | 1 | Register-bus write strobe |
| regWrData | input | 8 | Register-bus write data |
| regRdData | output | 8 | Register-bus read data for regAddr |
| romEn | output | 1 | ROM read enable |
| romAddr | output | 10 | ROM word address |
| romData | input | 14 | ROM word, valid one cycle after romEn |
| dmWrEn | output | 1 | Data-memory write strobe |
| dmWrAddr | output | 8 | Data-memory write address |
| dmWrData | output | 8 | Data-memory write data |
| busy | output | 1 | Core stall during the issue cycle |

## Verification
The stall, ROM enable and ROM address appear in the issue cycle itself. The bench drives each command just after a falling edge and samples one nanosecond before the next rising edge. The data-memory strobe, address and byte follow exactly one rising edge later, and the high-byte register is visible on the read port one further edge after that. The bench samples each result at that point in the same late part of the low phase. The sweep covers every pointer value under both page modes and all four program counter pages.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WRITE = 1'b1} tblrd_state_e;

  typedef struct packed {
    logic romRd;
    logic lastPage;
    logic capDest;
    logic wrBack;
  } tblrd_ctl_t;
endpackage

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdLastPage,
  output tblrd_ctl_t ctl,
  output logic       busy
);
  tblrd_state_e stateQ, stateD;
  logic issue;

  assign issue = (stateQ == ST_IDLE) && cmdValid;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (cmdValid) stateD = ST_WRITE;
      ST_WRITE: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl.romRd    = issue;
    ctl.lastPage = cmdLastPage;
    ctl.capDest  = issue;
    ctl.wrBack   = (stateQ == ST_WRITE);
  end

  assign busy = issue;
endmodule

// File: rtl/tblrd_dpath.sv
module tblrd_dpath
  import tblrd_pkg::*;
#(
  parameter int PAGE_W     = 2,
  parameter int PTR_W      = 8,
  parameter int WORD_W     = 14,
  parameter int DM_AW      = 8,
  parameter int REG_AW     = 8,
  parameter logic [REG_AW-1:0] PTR_ADDR  = 8'h07,
  parameter logic [REG_AW-1:0] HIGH_ADDR = 8'h08,
  localparam int ROM_AW = PAGE_W + PTR_W,
  localparam int HI_W   = WORD_W - PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblrd_ctl_t        ctl,
  input  logic [DM_AW-1:0]  cmdDest,
  input  logic [PAGE_W-1:0] pcHi,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [PTR_W-1:0]  regWrData,
  output logic [PTR_W-1:0]  regRdData,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [WORD_W-1:0] romData,
  output logic              dmWrEn,
  output logic [DM_AW-1:0]  dmWrAddr,
  output logic [PTR_W-1:0]  dmWrData
);
  logic [PTR_W-1:0] ptrQ;
  logic [PTR_W-1:0] highQ;
  logic [DM_AW-1:0] destQ;
  logic [PAGE_W-1:0] pageSel;

  assign pageSel = ctl.lastPage ? {PAGE_W{1'b1}} : pcHi;
  assign romAddr = {pageSel, ptrQ};
  assign romEn   = ctl.romRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrQ <= '0;
    else if (regWr && regAddr == PTR_ADDR) ptrQ <= regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) destQ <= '0;
    else if (ctl.capDest) destQ <= cmdDest;
  end

  generate
    if (HI_W < PTR_W) begin : g_padHigh
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) highQ <= '0;
        else if (ctl.wrBack) highQ <= {{(PTR_W-HI_W){1'b0}}, romData[WORD_W-1:PTR_W]};
      end
    end else begin : g_fullHigh
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) highQ <= '0;
        else if (ctl.wrBack) highQ <= romData[PTR_W +: PTR_W];
      end
    end
  endgenerate

  assign dmWrEn   = ctl.wrBack;
  assign dmWrAddr = destQ;
  assign dmWrData = romData[PTR_W-1:0];

  always_comb begin
    if (regAddr == PTR_ADDR)       regRdData = ptrQ;
    else if (regAddr == HIGH_ADDR) regRdData = highQ;
    else                           regRdData = '0;
  end
endmodule

// File: rtl/tblrd_top.sv
module tblrd_top
  import tblrd_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int PTR_W  = 8,
  parameter int WORD_W = 14,
  parameter int DM_AW  = 8,
  parameter int REG_AW = 8,
  localparam int ROM_AW = PAGE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdLastPage,
  input  logic [DM_AW-1:0]  cmdDest,
  input  logic [PAGE_W-1:0] pcHi,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic [PTR_W-1:0]  regWrData,
  output logic [PTR_W-1:0]  regRdData,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [WORD_W-1:0] romData,
  output logic              dmWrEn,
  output logic [DM_AW-1:0]  dmWrAddr,
  output logic [PTR_W-1:0]  dmWrData,
  output logic              busy
);
  tblrd_ctl_t ctl;

  tblrd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLastPage(cmdLastPage),
    .ctl(ctl), .busy(busy)
  );

  tblrd_dpath #(
    .PAGE_W(PAGE_W), .PTR_W(PTR_W), .WORD_W(WORD_W), .DM_AW(DM_AW), .REG_AW(REG_AW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdDest(cmdDest), .pcHi(pcHi),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
    .romEn(romEn), .romAddr(romAddr), .romData(romData),
    .dmWrEn(dmWrEn), .dmWrAddr(dmWrAddr), .dmWrData(dmWrData)
  );
endmodule

// File: rtl/tblrd_chk.sv
module tblrd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdLastPage,
  input logic [7:0] regAddr,
  input logic       regWr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       romEn,
  input logic [9:0] romAddr,
  input logic       dmWrEn,
  input logic       busy
);
  p_ptr_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWr && regAddr == 8'h07) && regAddr == 8'h07) |-> regRdData == $past(regWrData));

  p_high_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h08 && $past(regAddr == 8'h08) && !$past(dmWrEn)) |-> $stable(regRdData));

  p_last_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdLastPage) |-> romAddr[9:8] == 2'b11);

  p_busy_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  p_write_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    romEn |=> dmWrEn);

  p_high_pad_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h08) |-> regRdData[7:6] == 2'b00);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmWrEn |-> (!romEn && !busy));
endmodule

bind tblrd_top tblrd_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdLastPage(cmdLastPage), .regAddr(regAddr),
  .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
  .romEn(romEn), .romAddr(romAddr), .dmWrEn(dmWrEn), .busy(busy)
);

// File: tb/tblrd_top_tb_top.sv
`timescale 1ns/1ps
module tblrd_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdLastPage = 1'b0;
  logic [7:0] cmdDest = '0;
  logic [1:0] pcHi = '0;
  logic [7:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic romEn;
  logic [9:0] romAddr;
  logic [13:0] romData;
  logic dmWrEn;
  logic [7:0] dmWrAddr, dmWrData;
  logic busy;

  int tests = 0;
  int fails = 0;
  logic [13:0] rom [1024];

  always #2 clk = ~clk;

  function automatic logic [13:0] romWord(int a);
    return 14'(((a * 37) + 5) ^ (a << 3));
  endfunction

  initial for (int i = 0; i < 1024; i++) rom[i] = romWord(i);

  always_ff @(posedge clk) if (romEn) romData <= rom[romAddr];

  tblrd_top dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic readReg(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); regAddr = a; #1;
    check(req, regRdData, exp);
  endtask

  // Issue one command; holdValid keeps cmdValid high through the write cycle (R9)
  task automatic doCmd(logic last, logic [1:0] pc, logic [7:0] ptr, logic [7:0] dest, bit holdValid);
    logic [9:0] a;
    logic [13:0] w;
    a = last ? {2'b11, ptr} : {pc, ptr};
    w = romWord(int'(a));
    @(negedge clk);
    cmdValid = 1'b1; cmdLastPage = last; pcHi = pc; cmdDest = dest; #1;
    check("R6 busy", busy, 1);
    check(last ? "R5 romAddr" : "R4 romAddr", {romEn, romAddr}, {1'b1, a});
    @(negedge clk);
    cmdValid = holdValid; cmdDest = ~dest; #1;
    check("R7 write", {dmWrEn, dmWrAddr, dmWrData}, {1'b1, dest, w[7:0]});
    if (holdValid) check("R9 ignored", {busy, romEn}, 0);
    else           check("R6 busy low", busy, 0);
    @(negedge clk);
    cmdValid = 1'b0; regAddr = 8'h08; #1;
    check("R8 high", regRdData, {2'b00, w[13:8]});
    if (holdValid) check("R9 no second write", {dmWrEn, busy}, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 dmWrEn/romEn", {dmWrEn, romEn, busy}, 0);
    rstN = 1'b1;
    readReg("R1 ptr", 8'h07, 8'h00);
    readReg("R1 high", 8'h08, 8'h00);
    writeReg(8'h07, 8'hA5);
    readReg("R2 ptr", 8'h07, 8'hA5);
    readReg("R10 other", 8'h06, 8'h00);
    readReg("R10 other", 8'h09, 8'h00);
    writeReg(8'h08, 8'h3C);
    readReg("R3 high write ignored", 8'h08, 8'h00);
    for (int p = 0; p < 256; p++) begin
      writeReg(8'h07, 8'(p));
      readReg("R2 ptr sweep", 8'h07, 8'(p));
      doCmd(1'b0, 2'(p), 8'(p), 8'(p * 3 + 1), 1'b0);
      doCmd(1'b1, 2'(p + 1), 8'(p), 8'(p ^ 8'h5A), p[0]);
    end
    for (int pc = 0; pc < 4; pc++) begin
      writeReg(8'h07, 8'hFF);
      doCmd(1'b0, 2'(pc), 8'hFF, 8'(pc), 1'b1);
    end
    writeReg(8'h08, 8'h00);
    readReg("R3 high after write", 8'h08, {2'b00, romWord(int'({2'b11, 8'hFF}))[13:8]});
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule